// File: doc/BRIEF.md
# Expansion Port Region Decoder and Strobe Sequencer

This block watches a CPU bus, made up of a 24-bit address, an active-low address strobe, a read/write line and separate upper and lower byte write strobes. From that bus it drives active-low selects and DRAM-style strobes onto an expansion port. Three address windows are decoded:

- a boot ROM window;
- a DRAM window, with a row-strobe select;
- a narrow register window, which also receives a one-clock write pulse.

A row/column address-select strobe covers the whole lower half of the address space. For memory accesses the block plays out a fixed order after the address strobe falls: ROM or row select first, then the address-select strobe, then the column strobe. It also returns an acknowledge to the CPU ahead of the address-select strobe.

Everything runs from the CPU clock. Every delay is a whole number of clock ticks set by a parameter. All outputs are registered.

Top module: `xport_strobe_gen`

## Requirements
- R1: `rom_cs_n` is low during an access (address strobe low, read or write) whose address lies in 0x400000..0x5FFFFF, starting `RAS_DLY` clocks after the strobe is first sampled low (the first edge counts as 1).
- R2: `row_cs_n` behaves the same for addresses in 0x600000..0x7FFFFF.
- R3: `mux_sel_n` is low for addresses in 0x000000..0x7FFFFF from clock count `RAS_DLY+MUX_DLY` onward.
- R4: `col_cs_n` is low for addresses in 0x400000..0x7FFFFF from clock count `RAS_DLY+MUX_DLY+COL_DLY` onward.
- R5: `reg_cs_n` is low for reads and writes in 0xA12000..0xA120FF from the first edge that samples the strobe low.
- R6: `reg_wr_n` is low for exactly one clock, in the cycle after the edge at which either byte write strobe is first seen falling (both were high on the edge before). It fires only during a write (`rd_wr`=0) to the register window. This applies to word writes and to upper-only or lower-only byte writes.
- R7: With the default delays (1,1,1), the row or ROM select falls at count 1, the address select at count 2 and the column strobe at count 3.
- R8: `ack_n` is low for any access decoded by R3 or R5, from count `RAS_DLY`. It therefore precedes `mux_sel_n`.
- R9: Once an edge samples the address strobe high, every output is high after that edge.
- R10: A synchronous active-high reset drives every output high.
- R11: Addresses outside all windows (for example 0x800000, 0xA11FFF, 0xA12100) assert no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | synchronous reset, active high |
| addr | input | 24 | CPU byte address |
| as_n | input | 1 | address strobe, active low |
| rd_wr | input | 1 | 1 = read, 0 = write |
| uwr_n | input | 1 | upper byte write strobe, active low |
| lwr_n | input | 1 | lower byte write strobe, active low |
| rom_cs_n | output | 1 | boot ROM window select |
| row_cs_n | output | 1 | DRAM row strobe select |
| mux_sel_n | output | 1 | row/column address-select strobe |
| col_cs_n | output | 1 | column strobe |
| reg_cs_n | output | 1 | register window select |
| reg_wr_n | output | 1 | one-clock register write pulse |
| ack_n | output | 1 | acknowledge to the CPU |

## Verification
Each output is a register. Its value is a function of the inputs sampled at a rising edge and of how many consecutive edges have seen the address strobe low. A result is therefore due one edge after the stimulus that causes it, and the strobe sequence steps by one output per edge with default delays. The bench keeps its own count of strobe-low edges and predicts all seven outputs at every rising edge. Inputs are driven and outputs compared on falling edges, so each comparison lands half a clock after the edge that produced the value.

// File: rtl/xport_pkg.sv
package xport_pkg;
  typedef struct packed {
    logic rom;
    logic row;
    logic low_half;
    logic regw;
  } xport_hit_t;
endpackage

// File: rtl/xport_region_dec.sv
module xport_region_dec #(
  parameter int ADDR_W   = 24,
  parameter logic [ADDR_W-1:0] ROM_LO  = 24'h400000,
  parameter logic [ADDR_W-1:0] ROM_HI  = 24'h5FFFFF,
  parameter logic [ADDR_W-1:0] ROW_LO  = 24'h600000,
  parameter logic [ADDR_W-1:0] ROW_HI  = 24'h7FFFFF,
  parameter logic [ADDR_W-1:0] MUX_HI  = 24'h7FFFFF,
  parameter logic [ADDR_W-1:0] REG_LO  = 24'hA12000,
  parameter logic [ADDR_W-1:0] REG_HI  = 24'hA120FF
) (
  input  logic [ADDR_W-1:0]    addr,
  output xport_pkg::xport_hit_t hit
);
  always_comb begin
    hit.rom      = (addr >= ROM_LO) && (addr <= ROM_HI);
    hit.row      = (addr >= ROW_LO) && (addr <= ROW_HI);
    hit.low_half = (addr <= MUX_HI);
    hit.regw     = (addr >= REG_LO) && (addr <= REG_HI);
  end
endmodule

// File: rtl/xport_step_timer.sv
module xport_step_timer #(
  parameter int RAS_DLY = 1,
  parameter int MUX_DLY = 1,
  parameter int COL_DLY = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic as_n,
  output logic at_ras,
  output logic at_mux,
  output logic at_col
);
  localparam int TOTAL = RAS_DLY + MUX_DLY + COL_DLY;
  localparam int CW    = $clog2(TOTAL + 1) + 1;
  localparam logic [CW-1:0] T_RAS = CW'(RAS_DLY);
  localparam logic [CW-1:0] T_MUX = CW'(RAS_DLY + MUX_DLY);
  localparam logic [CW-1:0] T_COL = CW'(TOTAL);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (as_n)               cnt_d = '0;
    else if (cnt_q >= T_COL) cnt_d = cnt_q;
    else                    cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign at_ras = !as_n && (cnt_d >= T_RAS);
  assign at_mux = !as_n && (cnt_d >= T_MUX);
  assign at_col = !as_n && (cnt_d >= T_COL);
endmodule

// File: rtl/xport_wr_edge.sv
module xport_wr_edge (
  input  logic clk,
  input  logic rst,
  input  logic uwr_n,
  input  logic lwr_n,
  output logic fall
);
  logic any_now, any_q;
  assign any_now = !(uwr_n && lwr_n);

  always_ff @(posedge clk) begin
    if (rst) any_q <= 1'b0;
    else     any_q <= any_now;
  end

  assign fall = any_now && !any_q;
endmodule

// File: rtl/xport_strobe_gen.sv
module xport_strobe_gen #(
  parameter int ADDR_W  = 24,
  parameter int RAS_DLY = 1,
  parameter int MUX_DLY = 1,
  parameter int COL_DLY = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              as_n,
  input  logic              rd_wr,
  input  logic              uwr_n,
  input  logic              lwr_n,
  output logic              rom_cs_n,
  output logic              row_cs_n,
  output logic              mux_sel_n,
  output logic              col_cs_n,
  output logic              reg_cs_n,
  output logic              reg_wr_n,
  output logic              ack_n
);
  import xport_pkg::*;

  xport_hit_t hit;
  logic at_ras, at_mux, at_col, wr_fall, busy;

  xport_region_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr (addr),
    .hit  (hit)
  );

  xport_step_timer #(
    .RAS_DLY(RAS_DLY), .MUX_DLY(MUX_DLY), .COL_DLY(COL_DLY)
  ) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .as_n   (as_n),
    .at_ras (at_ras),
    .at_mux (at_mux),
    .at_col (at_col)
  );

  xport_wr_edge u_wr (
    .clk   (clk),
    .rst   (rst),
    .uwr_n (uwr_n),
    .lwr_n (lwr_n),
    .fall  (wr_fall)
  );

  assign busy = !as_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_cs_n  <= 1'b1;
      row_cs_n  <= 1'b1;
      mux_sel_n <= 1'b1;
      col_cs_n  <= 1'b1;
      reg_cs_n  <= 1'b1;
      reg_wr_n  <= 1'b1;
      ack_n     <= 1'b1;
    end else begin
      rom_cs_n  <= !(at_ras && hit.rom);
      row_cs_n  <= !(at_ras && hit.row);
      mux_sel_n <= !(at_mux && hit.low_half);
      col_cs_n  <= !(at_col && (hit.rom || hit.row));
      reg_cs_n  <= !(busy && hit.regw);
      reg_wr_n  <= !(busy && hit.regw && !rd_wr && wr_fall);
      ack_n     <= !(at_ras && (hit.low_half || hit.regw));
    end
  end
endmodule

// File: rtl/xport_strobe_gen_chk.sv
module xport_strobe_gen_chk (
  input logic clk,
  input logic rst,
  input logic as_n,
  input logic rom_cs_n,
  input logic row_cs_n,
  input logic mux_sel_n,
  input logic col_cs_n,
  input logic reg_cs_n,
  input logic reg_wr_n,
  input logic ack_n
);
  // R4
  col_after_mux_chk: assert property (@(posedge clk) disable iff (rst)
    !col_cs_n |-> !mux_sel_n);
  // R8
  ack_leads_mux_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mux_sel_n) |-> !ack_n);
  // R6
  wr_one_clock_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_wr_n |=> reg_wr_n);
  // R6
  wr_inside_window_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_wr_n |-> !reg_cs_n);
  // R1
  rom_row_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !rom_cs_n |-> row_cs_n);
  // R9
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    as_n |=> (rom_cs_n && row_cs_n && mux_sel_n && col_cs_n &&
              reg_cs_n && reg_wr_n && ack_n));
endmodule

bind xport_strobe_gen xport_strobe_gen_chk u_chk (
  .clk(clk), .rst(rst), .as_n(as_n),
  .rom_cs_n(rom_cs_n), .row_cs_n(row_cs_n), .mux_sel_n(mux_sel_n),
  .col_cs_n(col_cs_n), .reg_cs_n(reg_cs_n), .reg_wr_n(reg_wr_n),
  .ack_n(ack_n)
);

// File: tb/xport_strobe_gen_bench.sv
module xport_strobe_gen_bench;
  localparam int RD = 1, MD = 1, CD = 1;

  logic clk = 1'b0, rst = 1'b1;
  logic [23:0] addr = '0;
  logic as_n = 1'b1, rd_wr = 1'b1, uwr_n = 1'b1, lwr_n = 1'b1;
  logic rom_cs_n, row_cs_n, mux_sel_n, col_cs_n, reg_cs_n, reg_wr_n, ack_n;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  xport_strobe_gen u_xport_strobe_gen (
    .clk(clk), .rst(rst), .addr(addr), .as_n(as_n), .rd_wr(rd_wr),
    .uwr_n(uwr_n), .lwr_n(lwr_n), .rom_cs_n(rom_cs_n), .row_cs_n(row_cs_n),
    .mux_sel_n(mux_sel_n), .col_cs_n(col_cs_n), .reg_cs_n(reg_cs_n),
    .reg_wr_n(reg_wr_n), .ack_n(ack_n)
  );

  // behavioural reference
  int  low_edges = 0;
  bit  prev_any = 0;
  logic e_rom = 1, e_row = 1, e_mux = 1, e_col = 1, e_reg = 1, e_wr = 1, e_ack = 1;

  always @(posedge clk) begin
    bit in_rom, in_row, in_low, in_reg, any;
    in_rom = addr >= 24'h400000 && addr <= 24'h5FFFFF;
    in_row = addr >= 24'h600000 && addr <= 24'h7FFFFF;
    in_low = addr <= 24'h7FFFFF;
    in_reg = addr >= 24'hA12000 && addr <= 24'hA120FF;
    any    = !(uwr_n && lwr_n);
    if (rst) begin
      low_edges = 0; prev_any = 0;
      {e_rom, e_row, e_mux, e_col, e_reg, e_wr, e_ack} = 7'h7F;
    end else begin
      low_edges = as_n ? 0 : low_edges + 1;
      e_rom = !(!as_n && in_rom && low_edges >= RD);
      e_row = !(!as_n && in_row && low_edges >= RD);
      e_mux = !(!as_n && in_low && low_edges >= RD + MD);
      e_col = !(!as_n && (in_rom || in_row) && low_edges >= RD + MD + CD);
      e_reg = !(!as_n && in_reg);
      e_wr  = !(!as_n && in_reg && !rd_wr && any && !prev_any);
      e_ack = !(!as_n && (in_low || in_reg) && low_edges >= RD);
      prev_any = any;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst && !done) begin
    chk("R1 R7 rom_cs_n", rom_cs_n, e_rom);
    chk("R2 R7 row_cs_n", row_cs_n, e_row);
    chk("R3 R7 mux_sel_n", mux_sel_n, e_mux);
    chk("R4 R7 col_cs_n", col_cs_n, e_col);
    chk("R5 reg_cs_n", reg_cs_n, e_reg);
    chk("R6 reg_wr_n", reg_wr_n, e_wr);
    chk("R8 ack_n", ack_n, e_ack);
  end

  task automatic all_high(string tag);
    chk(tag, rom_cs_n & row_cs_n & mux_sel_n & col_cs_n & reg_cs_n & reg_wr_n & ack_n, 1'b1);
  endtask

  // mode: 0 read, 1 word write, 2 upper byte, 3 lower byte, 4 write strobe re-pulsed
  task automatic access(logic [23:0] a, int mode, int hold);
    @(negedge clk);
    addr = a; rd_wr = (mode == 0); as_n = 1'b0;
    @(negedge clk);
    if (mode == 1 || mode == 4) begin uwr_n = 0; lwr_n = 0; end
    if (mode == 2) uwr_n = 0;
    if (mode == 3) lwr_n = 0;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (mode == 4 && i == 1) begin uwr_n = 1; lwr_n = 1; end
      if (mode == 4 && i == 2) lwr_n = 0;
    end
    as_n = 1'b1; uwr_n = 1'b1; lwr_n = 1'b1; rd_wr = 1'b1;
    @(negedge clk);
    @(negedge clk);
    all_high("R9 release");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    all_high("R10 reset");
    rst = 1'b0;
    @(negedge clk);
    all_high("R10 after reset");
    // R7 directed sequence on a DRAM row access
    @(negedge clk); addr = 24'h612345; rd_wr = 1; as_n = 0;
    @(negedge clk); chk("R7 row at 1", row_cs_n, 0); chk("R7 mux at 1", mux_sel_n, 1); chk("R8 ack at 1", ack_n, 0);
    @(negedge clk); chk("R7 mux at 2", mux_sel_n, 0); chk("R7 col at 2", col_cs_n, 1);
    @(negedge clk); chk("R7 col at 3", col_cs_n, 0);
    as_n = 1;
    @(negedge clk); @(negedge clk); all_high("R9 directed");
    access(24'h000100, 0, 5);
    access(24'h400000, 0, 5);
    access(24'h5FFFFF, 1, 5);
    access(24'h600000, 0, 4);
    access(24'h7FFFFF, 1, 6);
    access(24'h800000, 0, 4);   // R11
    access(24'hA11FFF, 1, 4);   // R11
    access(24'hA12100, 1, 4);   // R11
    access(24'hA12000, 0, 4);   // R5 read, R6 no pulse
    access(24'hA12000, 1, 5);   // R6 word
    access(24'hA12081, 2, 5);   // R6 upper byte
    access(24'hA120FF, 3, 5);   // R6 lower byte
    access(24'hA12010, 4, 6);   // R6 second falling edge
    access(24'h500000, 2, 3);   // R1 write
    @(negedge clk); rst = 1; addr = 24'h600000; as_n = 0;
    @(negedge clk); @(negedge clk); all_high("R10 reset mid-access");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule